// File: doc/BRIEF.md
# Tunneled Memory Request Framer

This block sits on the requesting side of a serial tunneling link. A local bus master hands it one memory read or write request at a time: a 32-bit address, a 4-bit byte-enable mask, 32 bits of write data and an 8-bit tag. For each accepted request the block builds a single 16-byte data frame and sends it out one byte per cycle on a valid/ready byte stream. Frames are produced on demand only. No frame is sent while no request is pending.

Each frame opens with a comma symbol and a subtype byte. Two bytes of low-latency GPIO follow, captured in the cycle the request is accepted, and then the requester's tag, which lets returned completions be matched to outstanding requests. The command payload comes next: a command code, the address, the byte-enable byte and four data bytes. A CRC8 over all preceding bytes closes the frame. The request side accepts nothing more until the last frame byte has been taken. Requests with an empty byte-enable mask are never accepted.

Top module: `tunnel_req_framer`

## Requirements
- R1: After reset `tx_valid` is low, and `req_ready` is high whenever the block is idle and `req_be` is non-zero.
- R2: A frame starts only after a request handshake (`req_valid` and `req_ready` high at a clock edge). `tx_valid` rises in the next cycle. The frame is exactly 16 byte handshakes, `tx_last` is high only on the 16th, and `tx_valid` is low in the cycle after it.
- R3: Byte 0 is the comma symbol (parameter, default 0xBC) and byte 1 is the frame subtype (parameter, default 0x00).
- R4: Byte 2 is `gpio_in[7:0]` and byte 3 is `gpio_in[15:8]`, both as sampled at the request handshake. Later changes of `gpio_in` do not alter the frame.
- R5: Byte 4 is `req_tag` unchanged.
- R6: Byte 5 is the command code: 0x01 when `req_write` is 1, 0x00 when it is 0.
- R7: Bytes 6 to 9 carry `req_addr`, most significant byte first (byte 6 = bits 31:24, byte 9 = bits 7:0).
- R8: Byte 10 is `{4'b0000, req_be}`: bit n of the mask enables data byte n, and the upper nibble is zero.
- R9: For a write, bytes 11 to 14 are `req_wdata` bits 31:24, 23:16, 15:8, 7:0 in that order. For a read they are 0x00 whatever `req_wdata` holds.
- R10: Byte 15 is a CRC8 over bytes 0 to 14, processed MSB first: polynomial 0x07, initial value 0x00, no reflection, no final XOR.
- R11: While `req_be` is 0, `req_ready` stays low and no frame starts.
- R12: `req_ready` is low from the request handshake up to and including the cycle in which byte 15 is handed over. A request held pending during that time is accepted in the following cycle.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Target address |
| req_be | input | 4 | Byte-enable mask, bit n for data byte n |
| req_wdata | input | 32 | Write data, byte n in bits 8n+7:8n |
| req_tag | input | 8 | Requester's identifier, copied into the frame |
| gpio_in | input | 16 | Low-latency GPIO levels sampled into each frame |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Downstream takes the byte this cycle |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks byte 15 (the CRC) |

## Verification
Two events can fall in the same clock edge: the hand-over of a frame's final CRC byte, and the arrival of the next request. The bench holds a second request valid for the whole of the first frame. It then checks that `req_ready` stays low through the cycle that presents byte 15, that `tx_valid` is low and `req_ready` is high in the next cycle, and that the second frame starts with the fields and GPIO value that were present when it was accepted. The first frame is also checked byte by byte, which confirms that inputs changed during transmission did not leak into it.

// File: rtl/tunnel_frame_pkg.sv
package tunnel_frame_pkg;

    localparam int FRAME_LEN = 16;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int CRC_IDX   = FRAME_LEN - 1;

    localparam logic [7:0] CMD_READ  = 8'h00;
    localparam logic [7:0] CMD_WRITE = 8'h01;

    typedef struct packed {
        logic        write;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [7:0]  tag;
        logic [15:0] gpio;
    } req_fields_t;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [7:0]       crc;
        req_fields_t      req;
    } framer_state_t;

endpackage

// File: rtl/tunnel_frame_crc8.sv
module tunnel_frame_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);

    logic [7:0] acc;

    always_comb begin
        acc = crc_in ^ data_in;
        for (int b = 0; b < 8; b++) begin
            acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/tunnel_frame_byte_sel.sv
module tunnel_frame_byte_sel
    import tunnel_frame_pkg::*;
#(
    parameter logic [7:0] COMMA_SYM     = 8'hBC,
    parameter logic [7:0] FRAME_SUBTYPE = 8'h00
) (
    input  req_fields_t      fields,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       crc,
    output logic [7:0]       byte_out
);

    logic [31:0] data_word;

    always_comb begin
        data_word = fields.write ? fields.wdata : 32'h0;
        case (idx)
            4'd0:    byte_out = COMMA_SYM;
            4'd1:    byte_out = FRAME_SUBTYPE;
            4'd2:    byte_out = fields.gpio[7:0];
            4'd3:    byte_out = fields.gpio[15:8];
            4'd4:    byte_out = fields.tag;
            4'd5:    byte_out = fields.write ? CMD_WRITE : CMD_READ;
            4'd6:    byte_out = fields.addr[31:24];
            4'd7:    byte_out = fields.addr[23:16];
            4'd8:    byte_out = fields.addr[15:8];
            4'd9:    byte_out = fields.addr[7:0];
            4'd10:   byte_out = {4'b0000, fields.be};
            4'd11:   byte_out = data_word[31:24];
            4'd12:   byte_out = data_word[23:16];
            4'd13:   byte_out = data_word[15:8];
            4'd14:   byte_out = data_word[7:0];
            default: byte_out = crc;
        endcase
    end

endmodule

// File: rtl/tunnel_req_framer.sv
module tunnel_req_framer
    import tunnel_frame_pkg::*;
#(
    parameter logic [7:0] COMMA_SYM     = 8'hBC,
    parameter logic [7:0] FRAME_SUBTYPE = 8'h00,
    parameter logic [7:0] CRC_POLY      = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    input  logic [7:0]  req_tag,
    input  logic [15:0] gpio_in,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CRC_IDX);

    framer_state_t state_d, state_q;
    logic [7:0]    cur_byte;
    logic [7:0]    crc_next;
    logic          at_last;

    tunnel_frame_byte_sel #(
        .COMMA_SYM     (COMMA_SYM),
        .FRAME_SUBTYPE (FRAME_SUBTYPE)
    ) i_byte_sel (
        .fields   (state_q.req),
        .idx      (state_q.idx),
        .crc      (state_q.crc),
        .byte_out (cur_byte)
    );

    tunnel_frame_crc8 #(
        .POLY (CRC_POLY)
    ) i_crc8 (
        .crc_in  (state_q.crc),
        .data_in (cur_byte),
        .crc_out (crc_next)
    );

    assign at_last   = state_q.idx == LAST_IDX;
    assign req_ready = !state_q.busy && (req_be != 4'd0);
    assign tx_valid  = state_q.busy;
    assign tx_data   = cur_byte;
    assign tx_last   = state_q.busy && at_last;

    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (req_valid && req_ready) begin
                state_d.busy      = 1'b1;
                state_d.idx       = '0;
                state_d.crc       = 8'h00;
                state_d.req.write = req_write;
                state_d.req.addr  = req_addr;
                state_d.req.be    = req_be;
                state_d.req.wdata = req_wdata;
                state_d.req.tag   = req_tag;
                state_d.req.gpio  = gpio_in;
            end
        end else if (tx_ready) begin
            if (at_last) begin
                state_d.busy = 1'b0;
                state_d.idx  = '0;
            end else begin
                state_d.crc = crc_next;
                state_d.idx = state_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tunnel_req_framer_chk.sv
module tunnel_req_framer_chk #(
    parameter logic [7:0] COMMA_SYM = 8'hBC
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [3:0]  req_be,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last
);

    logic [3:0] hs_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_cnt <= 4'd0;
        end else if (tx_valid && tx_ready) begin
            hs_cnt <= tx_last ? 4'd0 : hs_cnt + 4'd1;
        end
    end

    assert_ready_needs_be_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (req_be != 4'd0));

    assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_no_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !req_ready);

    assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    assert_start_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(req_valid && req_ready));

    assert_comma_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (tx_valid && tx_data == COMMA_SYM && !tx_last));

    assert_frame_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_last == (hs_cnt == 4'd15)));

endmodule

bind tunnel_req_framer tunnel_req_framer_chk #(
    .COMMA_SYM (COMMA_SYM)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_be    (req_be),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last)
);

// File: tb/test_tunnel_req_framer.sv
`timescale 1ns/1ps
module test_tunnel_req_framer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [31:0] req_addr;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic [7:0]  req_tag;
    logic [15:0] gpio_in;
    logic        tx_valid;
    logic        tx_ready;
    logic [7:0]  tx_data;
    logic        tx_last;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_f [16];
    logic [7:0] got_f [16];

    always #2.5 clk = ~clk;

    tunnel_req_framer i_tunnel_req_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .req_tag   (req_tag),
        .gpio_in   (gpio_in),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    function automatic string byte_req(input int i);
        if (i < 2)   return "R3";
        if (i < 4)   return "R4";
        if (i == 4)  return "R5";
        if (i == 5)  return "R6";
        if (i < 10)  return "R7";
        if (i == 10) return "R8";
        if (i < 15)  return "R9";
        return "R10";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic build_exp(input logic w, input logic [31:0] a, input logic [3:0] be,
                             input logic [31:0] wd, input logic [7:0] tag, input logic [15:0] g);
        logic [7:0] c = 8'h00;
        exp_f[0] = 8'hBC;
        exp_f[1] = 8'h00;
        exp_f[2] = g[7:0];
        exp_f[3] = g[15:8];
        exp_f[4] = tag;
        exp_f[5] = w ? 8'h01 : 8'h00;
        for (int k = 0; k < 4; k++) begin
            exp_f[6 + k]  = a[31 - 8*k -: 8];
            exp_f[11 + k] = w ? wd[31 - 8*k -: 8] : 8'h00;
        end
        exp_f[10] = {4'h0, be};
        for (int k = 0; k < 15; k++) c = ref_crc(c, exp_f[k]);
        exp_f[15] = c;
    endtask

    task automatic set_req(input logic w, input logic [31:0] a, input logic [3:0] be,
                           input logic [31:0] wd, input logic [7:0] tag, input logic [15:0] g);
        req_write = w; req_addr = a; req_be = be; req_wdata = wd; req_tag = tag; gpio_in = g;
    endtask

    // Collects one frame; the block must be busy on entry.
    task automatic collect(input int mode);
        int got = 0;
        int cyc = 0;
        bit prev_stall = 1'b0;
        logic [7:0] prev_data = 8'h00;
        while (got < 16) begin
            @(negedge clk);
            tx_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            cyc++;
            if (prev_stall)
                check(tx_valid && tx_data == prev_data, "R13", "held byte", {23'h0, tx_valid, tx_data}, {24'h1, prev_data});
            check(tx_valid && !req_ready, "R12", "busy valid/ready", {tx_valid, req_ready}, 2'b10);
            if (tx_valid && tx_ready) begin
                check(tx_last == (got == 15), "R2", $sformatf("tx_last at byte %0d", got), tx_last, (got == 15));
                got_f[got] = tx_data;
                got++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
        end
        for (int k = 0; k < 16; k++)
            check(got_f[k] == exp_f[k], byte_req(k), $sformatf("frame byte %0d", k), got_f[k], exp_f[k]);
    endtask

    task automatic issue(input logic w, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input logic [7:0] tag, input logic [15:0] g);
        @(negedge clk);
        tx_ready = 1'b0;
        set_req(w, a, be, wd, tag, g);
        req_valid = 1'b1;
        build_exp(w, a, be, wd, tag, g);
        check(req_ready, "R1", "ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        gpio_in = ~g;            // R4: later GPIO change must not reach the frame
        req_wdata = ~wd;
        check(tx_valid, "R2", "valid after handshake", tx_valid, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; tx_ready = 1'b0;
        set_req(1'b0, 32'h0, 4'h1, 32'h0, 8'h0, 16'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);
        check(req_ready, "R1", "req_ready after reset", req_ready, 1);
        tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(!tx_valid, "R2", "no frame without request", tx_valid, 0);
    endtask

    task automatic t_write_full();
        issue(1'b1, 32'h12345678, 4'hF, 32'hA1B2C3D4, 8'h5A, 16'h3C96);
        collect(0);
    endtask

    task automatic t_read_stalled();
        issue(1'b0, 32'hDEADBEEF, 4'h3, 32'hFFFFFFFF, 8'hE7, 16'h0F0F);
        collect(1);
    endtask

    task automatic t_write_one_byte();
        issue(1'b1, 32'h0000_00FF, 4'h8, 32'h8000_0001, 8'h00, 16'hFFFF);
        collect(1);
    endtask

    task automatic t_zero_be();
        @(negedge clk);
        tx_ready = 1'b1;
        set_req(1'b1, 32'hCAFE0000, 4'h0, 32'h1, 8'h11, 16'h1234);
        req_valid = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!req_ready, "R11", "ready with empty mask", req_ready, 0);
            check(!tx_valid, "R11", "no frame for empty mask", tx_valid, 0);
        end
        req_valid = 1'b0;
        req_be = 4'h1;
        @(negedge clk);
        check(req_ready, "R11", "ready once mask non-zero", req_ready, 1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        tx_ready = 1'b0;
        set_req(1'b1, 32'h01020304, 4'h5, 32'h55AA33CC, 8'h21, 16'hBEEF);
        req_valid = 1'b1;
        build_exp(1'b1, 32'h01020304, 4'h5, 32'h55AA33CC, 8'h21, 16'hBEEF);
        @(negedge clk);
        // Second request held pending for the whole first frame.
        set_req(1'b0, 32'hF0E0D0C0, 4'hC, 32'h99999999, 8'h42, 16'h7E81);
        collect(0);
        @(negedge clk);
        check(!tx_valid, "R12", "idle after last byte", tx_valid, 0);
        check(req_ready, "R12", "ready after last byte", req_ready, 1);
        build_exp(1'b0, 32'hF0E0D0C0, 4'hC, 32'h99999999, 8'h42, 16'h7E81);
        @(negedge clk);
        req_valid = 1'b0;
        tx_ready = 1'b0;
        gpio_in = 16'h0000;
        check(tx_valid, "R12", "pending request started", tx_valid, 1);
        collect(0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write_full();
        t_read_stalled();
        t_write_one_byte();
        t_zero_be();
        t_back_to_back();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule